// File: doc/BRIEF.md
# Third-Order Noise-Shaping Modulus Generator

This block picks the division modulus for a fractional-N synthesizer, once per reference cycle. A fractional word K of FRAC_W bits and an integer base N are presented to it, together with a tick strobe. The strobe is high for one clock per reference (divider output) period. On each tick, three cascaded FRAC_W-bit accumulators advance. Each later accumulator adds the freshly updated sum of the one before it. A differentiation network combines their three carries into a signed offset, which is registered and added to N. The result drives the divider's modulus control. Over time the average modulus is N + K/2^FRAC_W. The quantization error is shaped by (1 - z^-1)^3, so the modulus moves among several integers around N. It does not toggle between N and N+1 with a short, spur-producing period.

A mode input selects a first-order variant, kept for comparison. In that mode the offset is simply the first accumulator's carry. The accumulators and delay registers keep running in either mode, so the mode can be switched at any time without a restart. The base N is assumed to be at least 3, so that the modulus never goes negative.

Top module: `mash3_frac_modulator`

## Requirements
- R1: A synchronous active-low reset clears all three accumulators, the carry delay registers and the registered offset. While reset is held and after it is released, modulus_o equals base_i until the first tick.
- R2: With order_one_i = 1, each tick sets the offset to the first accumulator's carry, so the offset is 0 or 1. Over any 2^FRAC_W consecutive ticks with constant K, exactly K of them give offset 1.
- R3: In third-order mode (order_one_i = 0), the offset always lies between -3 and +4 inclusive.
- R4: With K = 0 from reset, the offset stays 0 on every tick in both modes, so modulus_o equals base_i.
- R5: On a tick, accumulator 1 adds K modulo 2^FRAC_W. Accumulator 2 adds accumulator 1's new sum, and accumulator 3 adds accumulator 2's new sum. Each produces a carry c1, c2, c3 when its addition wraps. The third-order offset is c1 + c2 - c2' + c3 - 2*c3' + c3'', where ' marks the value from the previous tick and '' the value from two ticks back. These delayed values start at 0 after reset.
- R6: When tick_i is low, the accumulators, the delay registers and the offset hold their values.
- R7: In third-order mode with constant K, the offsets of any 2^FRAC_W consecutive ticks sum to within K-3 and K+3.
- R8: modulus_o equals base_i plus the registered offset combinationally, so a change of base_i shows at the output in the same cycle, without a tick.
- R9: Changing order_one_i between ticks changes only how the next offset is formed. The accumulators and carry delays carry on from their current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe per reference period; advances the modulator |
| frac_i | input | FRAC_W | Fractional word K |
| base_i | input | INT_W | Integer base N (assumed at least 3) |
| order_one_i | input | 1 | 1 selects first-order operation, 0 third-order |
| modulus_o | output | INT_W+1 | Modulus for the divider, N plus signed offset |

## Verification
The bench builds the block with FRAC_W = 6 and INT_W = 8. This makes one full accumulator period only 64 ticks long, so every window-sum property can be checked over hundreds of overlapping windows. The same setting reaches the extreme words K = 1 and K = 63 and the base boundary N = 3 quickly. With these small values, carries from all three stages occur densely, so every combination of the delayed carry terms, including the -3 and +4 extremes of the offset, appears within a short run.

// File: rtl/mash_mod_pkg.sv
// Shared types for the noise-shaping modulus generator.
// Assumes: offsets fit a 4-bit signed value (range -3..+4).
package mash_mod_pkg;
    typedef logic signed [3:0] shaped_off_t;

    typedef enum logic {
        ORDER_THREE = 1'b0,
        ORDER_ONE   = 1'b1
    } order_e;
endpackage

// File: rtl/mash_accum.sv
// One wrapping accumulator stage of the cascade.
// Exposes its next sum and carry combinationally, so the following stage
// can chain on the updated sum within the same tick.
// Assumes: tick is a single-cycle strobe; reset is synchronous, active low.
module mash_accum #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] addend_i,
    output logic [W-1:0] sum_next_o,
    output logic         carry_o
);
    logic [W-1:0] sum_q;
    logic [W:0]   wide;

    // Widened add: the top bit is the wrap carry.
    always_comb begin
        wide       = {1'b0, sum_q} + {1'b0, addend_i};
        sum_next_o = wide[W-1:0];
        carry_o    = wide[W];
    end

    // Sum register advances only on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    sum_q <= '0;
        else if (tick) sum_q <= sum_next_o;
    end

    // R4: a zero addend leaves the stored sum unchanged.
    p_zero_addend_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && addend_i == '0) |=> (sum_q == $past(sum_q)));

    // R6: no tick, no change.
    p_sum_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sum_q));
endmodule

// File: rtl/mash_combiner.sv
// Differentiation network: merges the three stage carries into a
// (1 - z^-1)^3 shaped signed offset, or passes the first carry alone in
// first-order mode. Carry delays advance on every tick in both modes.
// Assumes: carries are valid in the cycle tick is high.
module mash_combiner
    import mash_mod_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  order_e      order,
    input  logic [2:0]  carries_i,
    output shaped_off_t off_q
);
    logic        c2_d1;
    logic        c3_d1;
    logic        c3_d2;
    shaped_off_t full_off;
    shaped_off_t next_off;

    // Third-order sum of differenced carries, and the mode select.
    always_comb begin
        full_off = $signed({3'b000, carries_i[0]})
                 + $signed({3'b000, carries_i[1]}) - $signed({3'b000, c2_d1})
                 + $signed({3'b000, carries_i[2]}) - $signed({2'b00, c3_d1, 1'b0})
                 + $signed({3'b000, c3_d2});
        next_off = (order == ORDER_ONE) ? $signed({3'b000, carries_i[0]}) : full_off;
    end

    // Offset register and carry delay line, all advanced by the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= '0;
            c2_d1 <= 1'b0;
            c3_d1 <= 1'b0;
            c3_d2 <= 1'b0;
        end else if (tick) begin
            off_q <= next_off;
            c2_d1 <= carries_i[1];
            c3_d1 <= carries_i[2];
            c3_d2 <= c3_d1;
        end
    end

    // R3: shaped offset never leaves -3..+4.
    p_offset_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (off_q >= -4'sd3) && (off_q <= 4'sd4));

    // R2: first-order ticks yield 0 or 1 only.
    p_first_order_binary_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && order == ORDER_ONE) |=> (off_q == 4'sd0 || off_q == 4'sd1));

    // R6: offset holds between ticks.
    p_offset_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(off_q));
endmodule

// File: rtl/mash3_frac_modulator.sv
// Top level: three chained accumulators, the carry combiner, and the
// output adder forming base + signed offset for the divider.
// Assumes: base_i >= 3, so the modulus stays non-negative; tick_i is one
// cycle wide per reference period.
module mash3_frac_modulator
    import mash_mod_pkg::*;
#(
    parameter int FRAC_W = 16,
    parameter int INT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic [INT_W-1:0]  base_i,
    input  logic              order_one_i,
    output logic [INT_W:0]    modulus_o
);
    localparam int STAGES = 3;
    localparam int SUM_W  = INT_W + 2;

    logic [FRAC_W-1:0] stage_in  [STAGES];
    logic [FRAC_W-1:0] stage_sum [STAGES];
    logic [STAGES-1:0] stage_carry;
    shaped_off_t       off_q;
    logic signed [SUM_W-1:0] total;

    // Cascade: stage 0 adds K, each later stage adds its neighbour's new sum.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign stage_in[g] = frac_i;
        end else begin : g_tail
            assign stage_in[g] = stage_sum[g-1];
        end
        mash_accum #(.W(FRAC_W)) accum_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick_i),
            .addend_i   (stage_in[g]),
            .sum_next_o (stage_sum[g]),
            .carry_o    (stage_carry[g])
        );
    end

    mash_combiner comb_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_i),
        .order     (order_e'(order_one_i)),
        .carries_i (stage_carry),
        .off_q     (off_q)
    );

    // Output adder: base plus sign-extended offset.
    always_comb begin
        total     = $signed({2'b00, base_i}) + $signed({{(SUM_W-4){off_q[3]}}, off_q});
        modulus_o = total[INT_W:0];
    end
endmodule

// File: tb/mash3_frac_modulator_tb_top.sv
`timescale 1ns/1ps
module mash3_frac_modulator_tb_top;
    localparam int FW = 6;
    localparam int IW = 8;
    localparam int M  = 1 << FW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_i = 1'b0;
    logic [FW-1:0] frac_i = '0;
    logic [IW-1:0] base_i = 8'd100;
    logic          order_one_i = 1'b0;
    logic [IW:0]   modulus_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // Reference model state.
    int a1, a2, a3, c2p, c3p, c3pp, eoff;
    int win[$];
    int last_k = -1;
    int last_ord = -1;

    always #2 clk = ~clk;

    mash3_frac_modulator #(.FRAC_W(FW), .INT_W(IW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .frac_i(frac_i),
        .base_i(base_i), .order_one_i(order_one_i), .modulus_o(modulus_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        a1 = 0; a2 = 0; a3 = 0; c2p = 0; c3p = 0; c3pp = 0; eoff = 0;
        win.delete();
        last_k = -1; last_ord = -1;
    endtask

    // Behavioural model of one tick.
    task automatic model_tick(input int k, input int ord);
        int c1, c2, c3;
        a1 += k;  c1 = (a1 >= M); a1 %= M;
        a2 += a1; c2 = (a2 >= M); a2 %= M;
        a3 += a2; c3 = (a3 >= M); a3 %= M;
        if (ord == 1) eoff = c1;
        else          eoff = c1 + c2 - c2p + c3 - 2 * c3p + c3pp;
        c2p = c2; c3pp = c3p; c3p = c3;
    endtask

    task automatic do_reset(input int n);
        @(negedge clk);
        rst_n = 1'b0; tick_i = 1'b0; base_i = IW'(n);
        @(posedge clk);
        model_clear();
        #1 chk(int'(modulus_o) == n, "R1", int'(modulus_o), n);
        @(negedge clk);
        rst_n = 1'b1;
        #1 chk(int'(modulus_o) == n, "R1", int'(modulus_o), n);
    endtask

    task automatic step(input bit en, input int k, input int n, input int ord, input string tag);
        int s;
        @(negedge clk);
        tick_i = en; frac_i = FW'(k); base_i = IW'(n); order_one_i = (ord == 1);
        @(posedge clk);
        if (en) model_tick(k, ord);
        #1;
        chk(int'(modulus_o) == n + eoff, tag, int'(modulus_o), n + eoff);
        if (en) begin
            if (ord == 0) chk(eoff >= -3 && eoff <= 4, "R3", eoff, 0);
            if (k == 0)   chk(eoff == 0, "R4", eoff, 0);
            if (k != last_k || ord != last_ord) win.delete();
            last_k = k; last_ord = ord;
            win.push_back(eoff);
            if (win.size() > M) void'(win.pop_front());
            if (win.size() == M) begin
                s = 0;
                foreach (win[i]) s += win[i];
                if (ord == 1) chk(s == k, "R2", s, k);
                else          chk(s >= k - 3 && s <= k + 3, "R7", s, k);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        model_clear();
        do_reset(100);                                            // R1
        for (int i = 0; i < 70; i++) step(1, 0, 100, 0, "R4");    // K=0 third order
        for (int i = 0; i < 70; i++) step(1, 0, 100, 1, "R4");    // K=0 first order
        do_reset(120);
        for (int i = 0; i < 300; i++) step(1, 21, 120, 0, "R5");  // exact sequence
        for (int i = 0; i < 40; i++) step(i % 2 == 0, 21, 120, 0, "R6");
        for (int i = 0; i < 3; i++) step(0, 21, 50 + 70 * i, 0, "R8");
        step(0, 21, 37, 0, "R8");
        do_reset(90);
        for (int i = 0; i < 200; i++) step(1, 13, 90, 1, "R2");
        for (int i = 0; i < 100; i++) step(1, 13, 90, 0, "R9");   // switch, no reset
        for (int i = 0; i < 70; i++) step(1, 13, 90, 1, "R9");
        do_reset(200);
        for (int i = 0; i < 200; i++) step(1, 63, 200, 0, "R7");
        for (int i = 0; i < 200; i++) step(1, 1, 3, 0, "R7");     // base boundary N=3
        for (int i = 0; i < 150; i++) step(1, 42, 255, 0, "R5");
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule